// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a master for the two-wire clause-22 station management interface used to reach Ethernet PHY registers. Software hands it a single 32-bit command word containing the whole frame body: start pattern, operation, PHY address, register address, turnaround and 16 data bits. The block then produces a management clock from the system clock and shifts out a preamble of 32 ones followed by the command word, most significant bit first.

On a read operation the master releases the data line for the turnaround and data bits. It samples what the PHY drives back into the low 18 bits of the stored command word, so that `cmd_rdata[15:0]` holds the register contents once the transfer has finished. An idle flag tells software when the result is valid. A port enable input gates all activity on the management pins.

The management clock divider is picked from four ratios (8, 16, 32, 64). Software chooses the smallest ratio that keeps the management clock at or below 2.5 MHz: 64 above 80 MHz, 32 above 40 MHz, 16 above 20 MHz, and 8 otherwise.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `cmd_rdata` is 0.
- R2: `div_sel` value s selects a management clock period of 8<<s system clocks (0:8, 1:16, 2:32, 3:64). In each period `mdc` is low for the first half and high for the second half. The ratio is captured when a command is accepted, and later changes to `div_sel` do not affect the frame in progress.
- R3: When `cmd_wr` is high on a clock edge while `idle` is 1 and `port_en` is 1, the word is stored, `idle` is 0 from that edge on, and `idle` returns to 1 exactly 64 management clock periods after that edge.
- R4: The frame is 32 bits of 1 followed by command bits 31 down to 0. Each bit is held for one full `mdc` period, and a new bit appears in the same cycle that `mdc` goes low.
- R5: Command field positions are: start [31:30], opcode [29:28], PHY address [27:23], register address [22:18], turnaround [17:16], data [15:0]. Opcode 2'b10 is a read. For a read, `mdio_oe` is 0 for the last 18 frame bits. During those bits, `mdio_i` is sampled in the cycle `mdc` rises and stored into the matching command bit, while bits [31:18] keep their written value.
- R6: Any opcode other than 2'b10 is a write: all 64 bits are driven with `mdio_oe` at 1, and the stored word stays unchanged.
- R7: A `cmd_wr` while `idle` is 0 is ignored: the frame in progress and `cmd_rdata` are unaffected.
- R8: While `port_en` is 0, `mdc` and `mdio_oe` are 0 and `cmd_wr` is ignored. Dropping `port_en` during a frame aborts it, and `idle` is 1 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Management port enable |
| div_sel | input | 2 | Management clock ratio select (8<<div_sel) |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command word written |
| cmd_rdata | output | 32 | Stored command word, with read data after a read |
| idle | output | 1 | No transfer in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit counter or divider count shows up within one system clock as an `mdc` level or `mdio_o` value that differs from the expected waveform. The bench checks those pins against its own model on every cycle, so such an error is seen at once rather than at the end of the frame. A stuck busy flag shows as `idle` failing to return exactly 64 periods after acceptance. Corrupt read sampling shows in `cmd_rdata` as soon as `idle` rises. A command that was wrongly accepted while busy changes `cmd_rdata` and the shifted bits in the next cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int          CMD_W   = 32;
  localparam int          OP_HI   = 29;
  localparam int          OP_LO   = 28;
  localparam logic [1:0]  OP_RD   = 2'b10;
  localparam int          RX_BITS = 18;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIVSEL_W = 2,
  parameter int DIV_BASE = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                run,
  input  logic [DIVSEL_W-1:0] div_sel,
  output logic                rise_tick,
  output logic                fall_tick
);
  localparam int MAX_DIV = DIV_BASE << ((1 << DIVSEL_W) - 1);
  localparam int CNT_W   = $clog2(MAX_DIV);

  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [DIVSEL_W-1:0] sel_q, sel_d;
  logic [CNT_W:0]      period, half;

  always_comb begin
    period    = (CNT_W+1)'(DIV_BASE) << sel_q;
    half      = period >> 1;
    rise_tick = run && ({1'b0, cnt_q} == half - 1'b1);
    fall_tick = run && ({1'b0, cnt_q} == period - 1'b1);
  end

  always_comb begin
    cnt_d = cnt_q;
    sel_d = sel_q;
    if (start) begin
      cnt_d = '0;
      sel_d = div_sel;
    end else if (run) begin
      cnt_d = fall_tick ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  // R2: the ratio stays fixed while a frame runs
  assert_ratio_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && $past(run)) |-> $stable(sel_q));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
  parameter int FRAME_LEN = 64,
  localparam int BIT_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             port_en,
  input  logic             rise_tick,
  input  logic             fall_tick,
  output logic             busy,
  output logic [BIT_W-1:0] bit_idx,
  output logic             mdc_lvl
);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(FRAME_LEN - 1);

  logic             busy_d, mdc_d;
  logic [BIT_W-1:0] bit_d;

  always_comb begin
    busy_d = busy;
    bit_d  = bit_idx;
    mdc_d  = mdc_lvl;
    if (start) begin
      busy_d = 1'b1;
      bit_d  = '0;
      mdc_d  = 1'b0;
    end else if (!busy || !port_en) begin
      busy_d = 1'b0;
      mdc_d  = 1'b0;
    end else begin
      if (rise_tick) mdc_d = 1'b1;
      if (fall_tick) begin
        mdc_d = 1'b0;
        if (bit_idx == LAST) busy_d = 1'b0;
        else                 bit_d  = bit_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_idx <= '0;
      mdc_lvl <= 1'b0;
    end else begin
      busy    <= busy_d;
      bit_idx <= bit_d;
      mdc_lvl <= mdc_d;
    end
  end

  // R3: every frame begins at bit zero
  assert_frame_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bit_idx == '0) && !mdc_lvl);
  // R4: a new bit only appears together with a falling clock
  assert_bit_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (bit_idx != $past(bit_idx))) |-> (!mdc_lvl && $past(mdc_lvl)));
  // R2: the clock only rises inside a frame
  assert_mdc_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_lvl) |-> busy);
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
  import mdio_pkg::*;
#(
  parameter int PRE_LEN   = 32,
  localparam int FRAME_LEN = PRE_LEN + CMD_W,
  localparam int BIT_W     = $clog2(FRAME_LEN),
  localparam int IDX_W     = $clog2(CMD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CMD_W-1:0] wdata,
  input  logic             busy,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             rise_tick,
  input  logic             mdio_i,
  output logic [CMD_W-1:0] cmd_q,
  output logic             tx_bit,
  output logic             tx_en
);
  localparam logic [BIT_W-1:0] RX_FIRST = BIT_W'(FRAME_LEN - RX_BITS);
  localparam logic [BIT_W-1:0] PRE_B    = BIT_W'(PRE_LEN);

  logic [CMD_W-1:0] cmd_d;
  logic [BIT_W-1:0] wpos;
  logic [IDX_W-1:0] widx;
  logic             is_read, rx_win;

  always_comb begin
    is_read = (cmd_q[OP_HI:OP_LO] == OP_RD);
    wpos    = bit_idx - PRE_B;
    widx    = IDX_W'(CMD_W - 1) - wpos[IDX_W-1:0];
    rx_win  = (bit_idx >= RX_FIRST);
    tx_bit  = (bit_idx < PRE_B) ? 1'b1 : cmd_q[widx];
    tx_en   = busy && !(is_read && rx_win);
  end

  always_comb begin
    cmd_d = cmd_q;
    if (start)
      cmd_d = wdata;
    else if (busy && is_read && rx_win && rise_tick)
      cmd_d[widx] = mdio_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end

  // R7: the upper fields stay untouched while a frame runs
  assert_upper_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (cmd_q[CMD_W-1:RX_BITS] == $past(cmd_q[CMD_W-1:RX_BITS])));
  // R6: a write frame leaves the stored word unchanged
  assert_write_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !is_read) |-> $stable(cmd_q));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int PRE_LEN  = 32,
  parameter int DIVSEL_W = 2,
  parameter int DIV_BASE = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                port_en,
  input  logic [DIVSEL_W-1:0] div_sel,
  input  logic                cmd_wr,
  input  logic [CMD_W-1:0]    cmd_wdata,
  output logic [CMD_W-1:0]    cmd_rdata,
  output logic                idle,
  output logic                mdc,
  output logic                mdio_o,
  output logic                mdio_oe,
  input  logic                mdio_i
);
  localparam int FRAME_LEN = PRE_LEN + CMD_W;
  localparam int BIT_W     = $clog2(FRAME_LEN);

  logic             start, run, busy, rise_tick, fall_tick, mdc_lvl, tx_bit, tx_en;
  logic [BIT_W-1:0] bit_idx;

  always_comb begin
    start = cmd_wr && !busy && port_en;
    run   = busy && port_en;
  end

  mdio_clk_gen #(.DIVSEL_W(DIVSEL_W), .DIV_BASE(DIV_BASE)) u_clk (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run), .div_sel(div_sel),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .port_en(port_en),
    .rise_tick(rise_tick), .fall_tick(fall_tick),
    .busy(busy), .bit_idx(bit_idx), .mdc_lvl(mdc_lvl)
  );

  mdio_cmd_reg #(.PRE_LEN(PRE_LEN)) u_cmd (
    .clk(clk), .rst_n(rst_n), .start(start), .wdata(cmd_wdata), .busy(busy),
    .bit_idx(bit_idx), .rise_tick(rise_tick), .mdio_i(mdio_i),
    .cmd_q(cmd_rdata), .tx_bit(tx_bit), .tx_en(tx_en)
  );

  always_comb begin
    idle    = !busy;
    mdc     = mdc_lvl && port_en;
    mdio_oe = tx_en && port_en;
    mdio_o  = tx_bit;
  end

  // R8: losing the port enable ends any frame on the next edge
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(port_en) |=> idle);
  // R7: a strobe while busy does not restart the frame
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && cmd_wr && port_en) |=> !($past(bit_idx) != '0 && bit_idx == '0 && !idle));
endmodule

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b0;
  logic [1:0]  div_sel = 2'd0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        idle, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // model state
  bit          m_busy = 0;
  int          m_e = 0;
  int          m_n = 8;
  logic [31:0] m_cmd = '0;
  logic [15:0] phy_data = '0;

  always #5 clk = ~clk;

  mdio_mgmt_master u0 (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_sel(div_sel),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .idle(idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic bit m_rd();
    return m_cmd[29:28] == 2'b10;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference, advanced on every edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_cmd = '0; m_e = 0;
    end else if (!m_busy) begin
      if (cmd_wr && port_en) begin
        m_busy = 1; m_e = 0; m_n = 8 << div_sel; m_cmd = cmd_wdata;
      end
    end else if (!port_en) begin
      m_busy = 0;
    end else begin
      m_e++;
      if (m_rd() && (m_e / m_n) >= 46 && (m_e % m_n) == m_n / 2)
        m_cmd[63 - (m_e / m_n)] = mdio_i;
      if (m_e == 64 * m_n) m_busy = 0;
    end
  end

  // PHY side: drives turnaround and data of a read
  always @(posedge clk) begin
    #2;
    if (m_busy && m_rd() && (m_e / m_n) >= 46) begin
      if ((m_e / m_n) == 46)      mdio_i = 1'b1;
      else if ((m_e / m_n) == 47) mdio_i = 1'b0;
      else                        mdio_i = phy_data[63 - (m_e / m_n)];
    end else begin
      mdio_i = 1'b1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int b;
      bit exp_mdc, exp_oe, exp_o;
      b       = m_e / m_n;
      exp_mdc = port_en && m_busy && ((m_e % m_n) >= m_n / 2);
      exp_oe  = port_en && m_busy && !(m_rd() && b >= 46);
      exp_o   = (b < 32) ? 1'b1 : m_cmd[63 - b];
      check(mdc == exp_mdc, "R2 mdc", 32'(mdc), 32'(exp_mdc));
      check(mdio_oe == exp_oe, "R5 mdio_oe", 32'(mdio_oe), 32'(exp_oe));
      if (exp_oe) check(mdio_o == exp_o, "R4 mdio_o", 32'(mdio_o), 32'(exp_o));
      check(idle == !m_busy, "R3 idle", 32'(idle), 32'(!m_busy));
      check(cmd_rdata == m_cmd, "R5 cmd_rdata", cmd_rdata, m_cmd);
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic issue(input logic [31:0] w);
    @(posedge clk); #1 cmd_wr = 1'b1; cmd_wdata = w;
    @(posedge clk); #1 cmd_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] w1, w2, rd1, rd2, rd3;
    w1  = {2'b01, 2'b01, 5'h01, 5'h02, 2'b10, 16'hA5C3};
    w2  = {2'b01, 2'b01, 5'h1F, 5'h1E, 2'b10, 16'h5A3C};
    rd1 = {2'b01, 2'b10, 5'h03, 5'h01, 2'b00, 16'h0000};
    rd2 = {2'b01, 2'b10, 5'h11, 5'h04, 2'b11, 16'hFFFF};
    rd3 = {2'b01, 2'b10, 5'h05, 5'h05, 2'b00, 16'h1234};

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(idle == 1'b1, "R1 reset idle", 32'(idle), 32'd1);
    check(mdc == 1'b0, "R1 reset mdc", 32'(mdc), 32'd0);
    check(mdio_oe == 1'b0, "R1 reset oe", 32'(mdio_oe), 32'd0);
    check(cmd_rdata == '0, "R1 reset rdata", cmd_rdata, 32'd0);
    #1 rst_n = 1'b1;
    @(posedge clk); #1 port_en = 1'b1;

    // R6 write at ratio 8
    div_sel = 2'd0;
    issue(w1);
    @(negedge clk);
    check(idle == 1'b0, "R3 busy after accept", 32'(idle), 32'd0);
    wait_idle();
    check(cmd_rdata == w1, "R6 write word kept", cmd_rdata, w1);

    // R5 read at ratio 16
    div_sel = 2'd1; phy_data = 16'h3C96;
    issue(rd1);
    wait_idle();
    check(cmd_rdata == {rd1[31:18], 2'b10, 16'h3C96}, "R5 read data",
          cmd_rdata, {rd1[31:18], 2'b10, 16'h3C96});

    // R7 strobe mid-frame at ratio 32
    div_sel = 2'd2;
    issue(w1);
    repeat (100) @(posedge clk);
    issue(w2);
    @(negedge clk);
    check(cmd_rdata == w1, "R7 ignored while busy", cmd_rdata, w1);
    wait_idle();
    check(cmd_rdata == w1, "R7 word after frame", cmd_rdata, w1);

    // R2 ratio 64, select changed mid-frame; read with all ones
    div_sel = 2'd3; phy_data = 16'h8001;
    issue(rd2);
    repeat (40) @(posedge clk);
    #1 div_sel = 2'd0;
    wait_idle();
    check(cmd_rdata == {rd2[31:18], 2'b10, 16'h8001}, "R2 R5 read at 64",
          cmd_rdata, {rd2[31:18], 2'b10, 16'h8001});

    // R8 disabled port ignores commands
    @(posedge clk); #1 port_en = 1'b0;
    issue(w2);
    @(negedge clk);
    check(idle == 1'b1, "R8 idle while disabled", 32'(idle), 32'd1);
    check(cmd_rdata != w2, "R8 word not taken", cmd_rdata, {rd2[31:18], 2'b10, 16'h8001});

    // R8 abort mid-frame
    @(posedge clk); #1 port_en = 1'b1;
    phy_data = 16'h4321;
    issue(rd3);
    repeat (50) @(posedge clk);
    #1 port_en = 1'b0;
    @(negedge clk);
    check(mdc == 1'b0, "R8 mdc gated", 32'(mdc), 32'd0);
    @(negedge clk);
    check(idle == 1'b1, "R8 abort idle", 32'(idle), 32'd1);

    repeat (5) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule